// File: doc/BRIEF.md
# Gated Binary Decoder with Two-Way Cascade

This block turns a binary code into a single asserted line on a one-hot output bus. All outputs are active low. The basic cell takes a 3-bit select and gives eight outputs. It has three gate pins of mixed polarity: one active-high pin and two active-low pins. The cell drives any output low only when all three gate pins are in their asserted state. Otherwise every output stays high.

The top level builds a 16-output decoder from two of these cells. The most significant bit of the 4-bit code picks which cell is enabled. The three lower bits go to the select inputs of both cells. A small control module works out the gate pin levels for each cell from the top code bit and an overall enable. It passes these levels to the datapath in a strobe struct. The design is purely combinational, with no clock and no state.

Top module: `gated_cascade_decoder`

## Requirements
- R1: The basic cell is enabled only when `g1`=1, `g2aN`=0 and `g2bN`=0. For any other combination of the gate pins, all eight outputs of the cell are 1.
- R2: When the basic cell is enabled, output bit `i` is 0 exactly when the select value equals `i`. All other outputs are 1.
- R3: In the select vector, the highest bit has weight 4 and bit 0 has weight 1. For example, a select of 3'b100 drives output bit 4 low.
- R4: When `cascadeEn`=1, output `decN[k]` is 0 exactly when `code` equals `k`. The other fifteen outputs are 1.
- R5: When `cascadeEn`=1 and `code[3]`=0, outputs `decN[15:8]` are all 1. When `code[3]`=1, outputs `decN[7:0]` are all 1.
- R6: When `cascadeEn`=0, all sixteen outputs are 1 for every value of `code`.
- R7: No more than one output is 0 at any time, in the basic cell and in the cascade.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cascadeEn | input | 1 | Overall enable, active high |
| code | input | 4 | Binary code to decode; bit 3 chooses the half |
| decN | output | 16 | One-hot decoded lines, active low |

## Verification
The assertions check some properties every time an input changes:
- No more than one output is low.
- A gated-off cell or cascade holds all its outputs high.
- When enabled, the addressed line is the one that is low.
- The control strobes never enable both halves at the same time.

Only the bench's sweeps show the mapping from code values to line numbers, including the weight of each select bit. The bench applies every select value under all eight gate pin combinations to a standalone cell. It also applies every code to the cascade with the overall enable both on and off.

// File: rtl/gated_decoder_pkg.sv
package gated_decoder_pkg;

  localparam int HALVES = 2;

  // Gate pin levels for each sub-decoder, index 0 = low half, 1 = high half
  typedef struct packed {
    logic [HALVES-1:0] g1;
    logic [HALVES-1:0] g2aN;
    logic [HALVES-1:0] g2bN;
  } gate_strobes_t;

endpackage

// File: rtl/gated_decoder.sv
module gated_decoder #(
  parameter int SEL_W = 3
) (
  input  logic                  g1,
  input  logic                  g2aN,
  input  logic                  g2bN,
  input  logic [SEL_W-1:0]      sel,
  output logic [(1<<SEL_W)-1:0] outN
);

  localparam int OUT_N = 1 << SEL_W;

  logic gateOn;
  assign gateOn = g1 & ~g2aN & ~g2bN;

  genvar i;
  generate
    for (i = 0; i < OUT_N; i++) begin : g_line
      assign outN[i] = ~(gateOn && (sel == SEL_W'(i)));
    end
  endgenerate

  always_comb begin
    // R1
    if (!(g1 && !g2aN && !g2bN)) begin
      gated_off_high_chk: assert (&outN);
    end
    // R2
    if (g1 && !g2aN && !g2bN) begin
      addressed_low_chk: assert (outN[sel] == 1'b0);
    end
    // R7
    one_low_max_chk: assert ($countones(~outN) <= 1);
  end

endmodule

// File: rtl/cascade_ctrl.sv
module cascade_ctrl
  import gated_decoder_pkg::*;
(
  input  logic          cascadeEn,
  input  logic          topBit,
  output gate_strobes_t strobes
);

  always_comb begin
    // low half: active-high gate from the overall enable, topBit on an active-low gate
    strobes.g1[0]   = cascadeEn;
    strobes.g2aN[0] = topBit;
    strobes.g2bN[0] = 1'b0;
    // high half: topBit on the active-high gate, overall enable on an active-low gate
    strobes.g1[1]   = topBit;
    strobes.g2aN[1] = ~cascadeEn;
    strobes.g2bN[1] = 1'b0;
  end

  logic [HALVES-1:0] halfOn;
  assign halfOn = strobes.g1 & ~strobes.g2aN & ~strobes.g2bN;

  always_comb begin
    // R7
    single_half_chk: assert ($onehot0(halfOn));
    // R5
    if (cascadeEn) begin
      half_pick_chk: assert (halfOn[1] == topBit && halfOn[0] == !topBit);
    end
    // R6
    if (!cascadeEn) begin
      halves_idle_chk: assert (halfOn == '0);
    end
  end

endmodule

// File: rtl/gated_cascade_decoder.sv
module gated_cascade_decoder
  import gated_decoder_pkg::*;
#(
  parameter int SUB_W = 3
) (
  input  logic                          cascadeEn,
  input  logic [SUB_W:0]                code,
  output logic [(1<<(SUB_W+1))-1:0]     decN
);

  localparam int SUB_N  = 1 << SUB_W;
  localparam int CODE_W = SUB_W + 1;

  gate_strobes_t strobes;

  cascade_ctrl i_ctrl (
    .cascadeEn (cascadeEn),
    .topBit    (code[CODE_W-1]),
    .strobes   (strobes)
  );

  genvar h;
  generate
    for (h = 0; h < HALVES; h++) begin : g_half
      gated_decoder #(.SEL_W(SUB_W)) i_dec (
        .g1   (strobes.g1[h]),
        .g2aN (strobes.g2aN[h]),
        .g2bN (strobes.g2bN[h]),
        .sel  (code[SUB_W-1:0]),
        .outN (decN[h*SUB_N +: SUB_N])
      );
    end
  endgenerate

  always_comb begin
    // R4
    if (cascadeEn) begin
      line_select_chk: assert (decN[code] == 1'b0 && $countones(~decN) == 1);
    end
    // R6
    if (!cascadeEn) begin
      all_high_chk: assert (&decN);
    end
  end

endmodule

// File: tb/test_gated_cascade_decoder.sv
module test_gated_cascade_decoder;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        cascadeEn;
  logic [3:0]  code;
  logic [15:0] decN;

  logic        g1, g2aN, g2bN;
  logic [2:0]  sel;
  logic [7:0]  cellN;

  int total = 0;
  int bad   = 0;

  gated_cascade_decoder i_gated_cascade_decoder (
    .cascadeEn (cascadeEn),
    .code      (code),
    .decN      (decN)
  );

  gated_decoder #(.SEL_W(3)) i_gated_decoder (
    .g1   (g1),
    .g2aN (g2aN),
    .g2bN (g2bN),
    .sel  (sel),
    .outN (cellN)
  );

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    bit over = 0;
    fork
      begin
        // reset-like state: everything gated off
        cascadeEn = 1'b0; code = '0; g1 = 1'b0; g2aN = 1'b1; g2bN = 1'b1; sel = '0;
        @(negedge clk);
        check16("R6", decN, 16'hFFFF);
        check16("R1", {8'h00, cellN}, 16'h00FF);

        // basic cell: all gate combinations x all selects
        for (int g = 0; g < 8; g++) begin
          for (int s = 0; s < 8; s++) begin
            logic on;
            logic [7:0] expv;
            g1 = g[2]; g2aN = g[1]; g2bN = g[0]; sel = 3'(s);
            @(negedge clk);
            on   = (g == 4);
            expv = on ? ~(8'h01 << s) : 8'hFF;
            check16(on ? "R2" : "R1", {8'h00, cellN}, {8'h00, expv});
            total++;
            if ($countones(~cellN) > 1) begin
              bad++;
              $display("FAIL R7 actual=%0d expected<=1", $countones(~cellN));
            end
          end
        end

        // R3: weight of the select bits
        g1 = 1'b1; g2aN = 1'b0; g2bN = 1'b0; sel = 3'b100;
        @(negedge clk);
        check16("R3", {8'h00, cellN}, 16'h00EF);
        sel = 3'b001;
        @(negedge clk);
        check16("R3", {8'h00, cellN}, 16'h00FD);

        // cascade: both enables, all codes
        for (int e = 0; e < 2; e++) begin
          for (int c = 0; c < 16; c++) begin
            cascadeEn = e[0]; code = 4'(c);
            @(negedge clk);
            if (e == 0) check16("R6", decN, 16'hFFFF);
            else begin
              check16("R4", decN, ~(16'h0001 << c));
              if (c < 8) check16("R5", {8'h00, decN[15:8]}, 16'h00FF);
              else       check16("R5", {8'h00, decN[7:0]},  16'h00FF);
              total++;
              if ($countones(~decN) != 1) begin
                bad++;
                $display("FAIL R7 actual=%0d expected=1", $countones(~decN));
              end
            end
          end
        end
        over = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!over) begin
          total++; bad++;
          $display("FAIL watchdog actual=timeout expected=done");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule